// File: doc/BRIEF.md
# Table-Driven Operand Sequencer with Display Selector

This block sits in front of a combinational arithmetic unit on a small demonstration board. It holds a constant table of sixteen 20-bit words. A registered index picks one word, and the word splits into an opcode and two 8-bit operands that go to the arithmetic neighbour. Two active-low pushbuttons control the index. A step button moves it forward by one entry. A reset button sends it back to entry 0. Each button acts only after it has been pressed and then let go.

An 8-bit LED output shows one of sixteen views, chosen by a 4-bit switch input. The views include the index, the opcode, either operand, the neighbour's result and status flags, and the two bytes of a fixed 16-bit BCD tag. The neighbour's result and flags come back in on input ports.

Each button goes through a two-flop synchronizer and then a two-state machine. The states are `BTN_UP` (button released) and `BTN_DOWN` (button held). The transition `BTN_UP -> BTN_DOWN` happens when the synchronized sample is low. The transition `BTN_DOWN -> BTN_UP` happens when the sample is high, and it raises a one-cycle release pulse. In every other case the machine stays in its current state.

Top module: `opseq_panel`

## Requirements
- R1: Each table word has this layout: opcode in bits 19:16, operand A in bits 15:8, operand B in bits 7:0. The `opcode`, `opnd_a` and `opnd_b` outputs follow the word at the current index without a clock delay. With the default table, word 0 is 20'h4AA11.
- R2: A complete step press (low, then high again) raises the index by one on the third rising clock edge after the input returns high. A press that has not been released leaves the index unchanged.
- R3: The index wraps from 15 to 0. Bits 7:4 of the 8-bit `addr` output are always 0.
- R4: A complete reset press sets the index to 0 on the third rising edge after the reset input returns high. If a step release and a reset release are detected in the same cycle, reset wins.
- R5: The `led` output depends on the `sel_sw` code as follows: 4'b1000 shows `addr`; 4'b1001 shows {4'b0000, opcode}; 4'b1010 shows operand A; 4'b1011 shows operand B; 4'b1100 shows `alu_result`.
- R6: Code 4'b1101 shows {4'b0000, V, Z, C, N}, with `alu_flags[3]`=V, [2]=Z, [1]=C and [0]=N. Code 4'b1110 shows bits 15:8 of the BCD tag, and code 4'b1111 shows bits 7:0.
- R7: Codes 4'b0000 to 4'b0110 show 8'h00. Code 4'b0111 shows {4'b0000, opcode}.
- R8: At power-up the index is 0 and both buttons are in the released state.
- R9: Holding a button down for any number of cycles produces exactly one step, and that step happens at the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock, rising edge |
| rst_btn_n | input | 1 | Reset pushbutton, active low, acts on release |
| step_btn_n | input | 1 | Step pushbutton, active low, acts on release |
| sel_sw | input | 4 | Switch code that selects the LED view |
| alu_result | input | 8 | Result from the arithmetic neighbour |
| alu_flags | input | 4 | Flags from the neighbour: V, Z, C, N (bit 3 down to bit 0) |
| opcode | output | 4 | Opcode field of the current word |
| opnd_a | output | 8 | Operand A field of the current word |
| opnd_b | output | 8 | Operand B field of the current word |
| addr | output | 8 | Current table index, upper bits zero |
| led | output | 8 | The selected view |

## Verification
The index properties assume that the reset button is released whenever they are evaluated, so they are disabled while `rst_btn_n` is low. They also assume that no new press starts within three cycles of a release. The stimulus holds the buttons steady between clock-edge pairs and leaves a gap of at least four cycles between presses. The switch and flag inputs change only at falling edges, so every view comparison sees stable inputs.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
    localparam int OP_W     = 4;
    localparam int DATA_W   = 8;
    localparam int WORD_W   = OP_W + 2 * DATA_W;
    localparam int TBL_D    = 16;
    localparam int IDX_W    = $clog2(TBL_D);
    localparam int SEL_W    = 4;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } tbl_word_t;

    typedef enum logic [SEL_W-1:0] {
        VIEW_DBG_OP = 4'b0111,
        VIEW_ADDR   = 4'b1000,
        VIEW_OP     = 4'b1001,
        VIEW_A      = 4'b1010,
        VIEW_B      = 4'b1011,
        VIEW_RES    = 4'b1100,
        VIEW_FLAGS  = 4'b1101,
        VIEW_TAG_HI = 4'b1110,
        VIEW_TAG_LO = 4'b1111
    } view_t;

    typedef enum logic {
        BTN_UP   = 1'b0,
        BTN_DOWN = 1'b1
    } btn_state_t;
endpackage

// File: rtl/opseq_btn_fsm.sv
module opseq_btn_fsm #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic btn_n,
    output logic release_p
);
    import opseq_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q = '1;
    btn_state_t state_q = BTN_UP;
    btn_state_t state_d;
    logic       level;

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        sync_q  <= {sync_q[SYNC_STAGES-2:0], btn_n};
        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        release_p = 1'b0;
        unique case (state_q)
            BTN_UP: begin
                if (!level) state_d = BTN_DOWN;
            end
            BTN_DOWN: begin
                if (level) begin
                    state_d   = BTN_UP;
                    release_p = 1'b1;
                end
            end
            default: state_d = BTN_UP;
        endcase
    end
endmodule

// File: rtl/opseq_addr_ctr.sv
module opseq_addr_ctr #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             clr_p,
    input  logic             adv_p,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] idx_q = '0;

    always_ff @(posedge clk) begin
        if (clr_p)
            idx_q <= '0;
        else if (adv_p)
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    assign idx = idx_q;
endmodule

// File: rtl/opseq_view_mux.sv
module opseq_view_mux #(
    parameter int          DATA_W = 8,
    parameter int          OP_W   = 4,
    parameter int          FLAG_W = 4,
    parameter logic [15:0] TAG    = 16'h0000
) (
    input  logic [3:0]        sel,
    input  logic [DATA_W-1:0] addr,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] res,
    input  logic [FLAG_W-1:0] flags,
    output logic [DATA_W-1:0] view
);
    import opseq_pkg::*;

    localparam int OP_PAD   = DATA_W - OP_W;
    localparam int FLAG_PAD = DATA_W - FLAG_W;

    logic [DATA_W-1:0] op_wide;
    logic [DATA_W-1:0] flag_wide;

    assign op_wide   = {{OP_PAD{1'b0}}, op};
    assign flag_wide = {{FLAG_PAD{1'b0}}, flags};

    always_comb begin
        unique case (sel)
            VIEW_DBG_OP: view = op_wide;
            VIEW_ADDR:   view = addr;
            VIEW_OP:     view = op_wide;
            VIEW_A:      view = a;
            VIEW_B:      view = b;
            VIEW_RES:    view = res;
            VIEW_FLAGS:  view = flag_wide;
            VIEW_TAG_HI: view = TAG[15:8];
            VIEW_TAG_LO: view = TAG[7:0];
            default:     view = '0;
        endcase
    end
endmodule

// File: rtl/opseq_panel.sv
module opseq_panel
    import opseq_pkg::*;
#(
    parameter int                 ADDR_OUT_W = 8,
    parameter logic [15:0]        BCD_TAG    = 16'h2718,
    parameter logic [WORD_W-1:0]  TABLE [TBL_D] = '{
        20'h4AA11, 20'h01234, 20'h1F00F, 20'h27F01, 20'h38080, 20'h5C35A, 20'h6FFFF, 20'h70000,
        20'h88001, 20'h9CB57, 20'hA5575, 20'hB299D, 20'hC0101, 20'hD7E7E, 20'hE00FF, 20'hF8181}
) (
    input  logic                  clk,
    input  logic                  rst_btn_n,
    input  logic                  step_btn_n,
    input  logic [SEL_W-1:0]      sel_sw,
    input  logic [DATA_W-1:0]     alu_result,
    input  logic [3:0]            alu_flags,
    output logic [OP_W-1:0]       opcode,
    output logic [DATA_W-1:0]     opnd_a,
    output logic [DATA_W-1:0]     opnd_b,
    output logic [ADDR_OUT_W-1:0] addr,
    output logic [DATA_W-1:0]     led
);
    localparam int ADDR_PAD = ADDR_OUT_W - IDX_W;

    logic             step_rel;
    logic             rst_rel;
    logic [IDX_W-1:0] idx;
    tbl_word_t        word;

    opseq_btn_fsm #(.SYNC_STAGES(2)) u_step (
        .clk       (clk),
        .btn_n     (step_btn_n),
        .release_p (step_rel)
    );

    opseq_btn_fsm #(.SYNC_STAGES(2)) u_rst (
        .clk       (clk),
        .btn_n     (rst_btn_n),
        .release_p (rst_rel)
    );

    opseq_addr_ctr #(.DEPTH(TBL_D), .IDX_W(IDX_W)) u_ctr (
        .clk   (clk),
        .clr_p (rst_rel),
        .adv_p (step_rel),
        .idx   (idx)
    );

    assign word   = tbl_word_t'(TABLE[idx]);
    assign opcode = word.op;
    assign opnd_a = word.a;
    assign opnd_b = word.b;
    assign addr   = {{ADDR_PAD{1'b0}}, idx};

    opseq_view_mux #(
        .DATA_W (DATA_W),
        .OP_W   (OP_W),
        .FLAG_W (4),
        .TAG    (BCD_TAG)
    ) u_view (
        .sel   (sel_sw),
        .addr  (addr[DATA_W-1:0]),
        .op    (word.op),
        .a     (word.a),
        .b     (word.b),
        .res   (alu_result),
        .flags (alu_flags),
        .view  (led)
    );
endmodule

// File: rtl/opseq_panel_chk.sv
module opseq_panel_chk (
    input logic       clk,
    input logic       rst_btn_n,
    input logic [3:0] sel_sw,
    input logic [3:0] alu_flags,
    input logic [7:0] led,
    input logic [7:0] addr,
    input logic       step_rel,
    input logic       rst_rel
);
    p_addr_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_btn_n)
        addr[7:4] == 4'd0);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_btn_n)
        (!step_rel && !rst_rel) |=> $stable(addr));

    p_addr_inc_r2: assert property (@(posedge clk) disable iff (!rst_btn_n)
        (step_rel && !rst_rel) |=> (addr[3:0] == $past(addr[3:0]) + 4'd1));

    p_reset_zero_r4: assert property (@(posedge clk) disable iff (!rst_btn_n)
        rst_rel |=> (addr == 8'd0));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_btn_n)
        step_rel |=> !step_rel);

    p_view_addr_r5: assert property (@(posedge clk) disable iff (!rst_btn_n)
        (sel_sw == 4'b1000) |-> (led == addr));

    p_view_flags_r6: assert property (@(posedge clk) disable iff (!rst_btn_n)
        (sel_sw == 4'b1101) |-> (led == {4'b0000, alu_flags}));

    p_view_blank_r7: assert property (@(posedge clk) disable iff (!rst_btn_n)
        (sel_sw < 4'b0111) |-> (led == 8'h00));
endmodule

bind opseq_panel opseq_panel_chk u_chk (
    .clk       (clk),
    .rst_btn_n (rst_btn_n),
    .sel_sw    (sel_sw),
    .alu_flags (alu_flags),
    .led       (led),
    .addr      (addr),
    .step_rel  (step_rel),
    .rst_rel   (rst_rel)
);

// File: tb/tb_opseq_panel.sv
module tb_opseq_panel;
    localparam logic [19:0] TB_TAB [16] = '{
        20'h4AA11, 20'h13C5A, 20'h2B67A, 20'h329D6, 20'h4177B, 20'h53EF3, 20'h64359, 20'h7B657,
        20'h8C672, 20'h9CB57, 20'hA5575, 20'hB299D, 20'hC8001, 20'hD00FF, 20'hE7F80, 20'hF0000};
    localparam logic [15:0] TB_TAG = 16'h5931;

    logic       clk = 1'b0;
    logic       rst_btn_n = 1'b1;
    logic       step_btn_n = 1'b1;
    logic [3:0] sel_sw = 4'd0;
    logic [7:0] alu_result = 8'h00;
    logic [3:0] alu_flags = 4'h0;
    logic [3:0] opcode;
    logic [7:0] opnd_a, opnd_b, addr, led;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    opseq_panel #(.BCD_TAG(TB_TAG), .TABLE(TB_TAB)) dut (
        .clk(clk), .rst_btn_n(rst_btn_n), .step_btn_n(step_btn_n), .sel_sw(sel_sw),
        .alu_result(alu_result), .alu_flags(alu_flags), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .addr(addr), .led(led));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int view_of(input int s, input int a, input int w, input int r, input int f);
        int op = (w >> 16) & 15;
        case (s)
            7, 9:    return op;
            8:       return a;
            10:      return (w >> 8) & 255;
            11:      return w & 255;
            12:      return r;
            13:      return f;
            14:      return TB_TAG >> 8;
            15:      return TB_TAG & 255;
            default: return 0;
        endcase
    endfunction

    // reference model: input samples per edge, release = rose two edges ago
    int hs[$] = '{1, 1, 1, 1};
    int hr[$] = '{1, 1, 1, 1};
    int m_addr = 0;

    always @(posedge clk) begin
        hs.push_back(int'(step_btn_n)); void'(hs.pop_front());
        hr.push_back(int'(rst_btn_n));  void'(hr.pop_front());
        if (hr[1] == 1 && hr[0] == 0) m_addr = 0;
        else if (hs[1] == 1 && hs[0] == 0) m_addr = (m_addr + 1) % 16;
        #2;
        if (!done) begin
            chk("R2 index", int'(addr), m_addr);
            chk("R1 opcode", int'(opcode), int'(TB_TAB[m_addr][19:16]));
            chk("R1 operandA", int'(opnd_a), int'(TB_TAB[m_addr][15:8]));
            chk("R1 operandB", int'(opnd_b), int'(TB_TAB[m_addr][7:0]));
            if (sel_sw < 4'd8)       chk("R7 view", int'(led), view_of(sel_sw, m_addr, TB_TAB[m_addr], alu_result, alu_flags));
            else if (sel_sw < 4'd13) chk("R5 view", int'(led), view_of(sel_sw, m_addr, TB_TAB[m_addr], alu_result, alu_flags));
            else                     chk("R6 view", int'(led), view_of(sel_sw, m_addr, TB_TAB[m_addr], alu_result, alu_flags));
        end
    end

    // free-running view selector and neighbour values
    initial begin
        forever begin
            @(negedge clk);
            sel_sw     <= sel_sw + 4'd1;
            alu_result <= alu_result * 8'd5 + 8'd3;
            alu_flags  <= alu_flags + 4'd7;
        end
    end

    task automatic press(input bit use_rst, input int hold, input int gap);
        @(negedge clk);
        if (use_rst) rst_btn_n = 1'b0; else step_btn_n = 1'b0;
        repeat (hold) @(negedge clk);
        if (use_rst) rst_btn_n = 1'b1; else step_btn_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        #1;
        chk("R8 power-up index", int'(addr), 0);
        chk("R1 word0 opcode", int'(opcode), 4);
        chk("R1 word0 A", int'(opnd_a), 'hAA);
        chk("R1 word0 B", int'(opnd_b), 'h11);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 3; i++) press(1'b0, 2, 5);
        chk("R2 three steps", int'(addr), 3);
        @(negedge clk); step_btn_n = 1'b0;
        repeat (40) @(negedge clk);
        chk("R2 held press no step", int'(addr), 3);
        step_btn_n = 1'b1;
        @(negedge clk);
        chk("R9 not yet at first edge", int'(addr), 3);
        repeat (4) @(negedge clk);
        chk("R9 one step after long hold", int'(addr), 4);
        press(1'b0, 1, 6);
        chk("R9 one-cycle press", int'(addr), 5);
        press(1'b1, 3, 6);
        chk("R4 reset release", int'(addr), 0);
        for (int i = 0; i < 18; i++) press(1'b0, 1 + (i % 3), 4);
        chk("R3 wrap after 18 steps", int'(addr), 2);
        chk("R3 upper bits zero", int'(addr[7:4]), 0);
        @(negedge clk); step_btn_n = 1'b0; rst_btn_n = 1'b0;
        repeat (3) @(negedge clk);
        step_btn_n = 1'b1; rst_btn_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R4 reset beats step", int'(addr), 0);
        for (int i = 0; i < 40; i++) press(1'b0, 2, 4 + (i % 5));
        repeat (10) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule